// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block produces a single programming pulse on the control lines of an embedded flash array. A higher-level programming controller raises a start strobe and picks a pulse class at the same time. The block then steps the watchdog-enable, setup and program lines through a fixed interlock. A shared down-counter paces each step, and a one-cycle done strobe marks the end.

All waits and pulse widths are parameters in microseconds and are converted to clock cycles through a clock-frequency parameter. At the defaults (100 MHz) the setup lead is 5000 cycles and each of the two trailing waits is 500 cycles. The short, normal and long pulses are 1000, 3000 and 20000 cycles. The pulse class is latched when a start is accepted, so later changes on the select input have no effect on a pulse already running.

Top module: `flash_pulse_seq`

## Requirements
- R1: While `rst_n` is low, `wdt_en_o`, `setup_o`, `prog_o`, `done_o` and `busy_o` are all 0, and they drop as soon as `rst_n` falls. After `rst_n` rises, the block ignores start for two clock edges and accepts it from the third.
- R2: A start sampled high at a clock edge while the block is idle is accepted. In the following cycle `busy_o` and `wdt_en_o` are 1 and `setup_o` is still 0.
- R3: `setup_o` rises exactly one cycle after `wdt_en_o`. It is high for SETUP cycles (default 5000) before `prog_o` rises. `setup_o` is never high while `wdt_en_o` is low.
- R4: `prog_o` stays high for a width set by the class latched at acceptance. 2'b00 gives the short width (default 1000 cycles), 2'b01 the normal width (3000), and 2'b10 or 2'b11 the long width (20000).
- R5: Whenever `prog_o` is high, `setup_o` is high.
- R6: After `prog_o` falls, `setup_o` stays high for ALPHA cycles (default 500). After `setup_o` falls, `wdt_en_o` stays high for BETA cycles (default 500).
- R7: `done_o` is high for exactly one cycle, in the cycle right after `wdt_en_o` falls. In that cycle `wdt_en_o`, `setup_o` and `prog_o` are low.
- R8: `busy_o` is high from the cycle after an accepted start through the done cycle, and low in the cycle after that.
- R9: A start while `busy_o` is high is ignored, including in the done cycle. A change of the class select during a pulse does not change that pulse's width.
- R10: While idle, all five outputs are 0 whatever the start and select inputs are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| start_i | input | 1 | Start request, sampled at each rising edge |
| pclass_i | input | 2 | Pulse class: 00 short, 01 normal, 10/11 long |
| wdt_en_o | output | 1 | Watchdog enable for the programming window |
| setup_o | output | 1 | Program setup line |
| prog_o | output | 1 | Program pulse line |
| busy_o | output | 1 | High while a pulse sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence strobe |

## Verification
The bench runs every pulse class, including the alternate long code 11. A width multiplexer that decoded 11 as short or normal would produce a pulse of the wrong length. Starts are raised partway through a pulse, together with a new class value; a design that re-latched the class would change the running width, and one that re-accepted the start would restart the interlock. A start placed exactly on the done cycle catches a design that treats done as idle and begins a second sequence with no gap. A reset dropped while the program line is high checks that the line clears at once, not at the next edge, and that the next pulse after release runs cleanly.

// File: rtl/flash_pulse_pkg.sv
package flash_pulse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_SETUP = 3'd2,
    ST_PROG  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_DRAIN = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    PC_ADD  = 2'b00,
    PC_NORM = 2'b01,
    PC_LONG = 2'b10,
    PC_ALT  = 2'b11
  } pclass_e;

  typedef struct packed {
    logic busy;
    logic wdt;
    logic setup;
    logic prog;
    logic done;
  } ctl_out_t;

  function automatic ctl_out_t ctl_decode(seq_state_e s);
    ctl_out_t c;
    c = '0;
    unique case (s)
      ST_IDLE:  c = '0;
      ST_ARM:   begin c.busy = 1'b1; c.wdt = 1'b1; end
      ST_SETUP: begin c.busy = 1'b1; c.wdt = 1'b1; c.setup = 1'b1; end
      ST_PROG:  begin c.busy = 1'b1; c.wdt = 1'b1; c.setup = 1'b1; c.prog = 1'b1; end
      ST_HOLD:  begin c.busy = 1'b1; c.wdt = 1'b1; c.setup = 1'b1; end
      ST_DRAIN: begin c.busy = 1'b1; c.wdt = 1'b1; end
      ST_DONE:  begin c.busy = 1'b1; c.done = 1'b1; end
      default:  c = '0;
    endcase
    return c;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/prog_width_sel.sv
module prog_width_sel
  import flash_pulse_pkg::*;
#(
  parameter int CW        = 16,
  parameter int SHORT_LD  = 0,
  parameter int NORMAL_LD = 0,
  parameter int LONG_LD   = 0
) (
  input  logic [1:0]    pclass_i,
  output logic [CW-1:0] width_ld_o
);

  always_comb begin
    unique case (pclass_e'(pclass_i))
      PC_ADD:  width_ld_o = CW'(SHORT_LD);
      PC_NORM: width_ld_o = CW'(NORMAL_LD);
      PC_LONG: width_ld_o = CW'(LONG_LD);
      PC_ALT:  width_ld_o = CW'(LONG_LD);
      default: width_ld_o = CW'(LONG_LD);
    endcase
  end

endmodule

// File: rtl/pulse_seq_fsm.sv
module pulse_seq_fsm
  import flash_pulse_pkg::*;
#(
  parameter int CW       = 16,
  parameter int SETUP_LD = 0,
  parameter int ALPHA_LD = 0,
  parameter int BETA_LD  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    pclass_i,
  input  logic          tmr_zero_i,
  input  logic [CW-1:0] prog_ld_i,
  output logic [1:0]    pclass_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output ctl_out_t      ctl_o
);

  seq_state_e state_q, state_d;
  logic [1:0] cls_q, cls_d;
  logic       cls_en;
  ctl_out_t   ctl_q, ctl_d;

  always_comb begin
    state_d    = state_q;
    cls_d      = cls_q;
    cls_en     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ARM;
          cls_d   = pclass_i;
          cls_en  = 1'b1;
        end
      end
      ST_ARM: begin
        state_d    = ST_SETUP;
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(SETUP_LD);
      end
      ST_SETUP: begin
        if (tmr_zero_i) begin
          state_d    = ST_PROG;
          tmr_load_o = 1'b1;
          tmr_val_o  = prog_ld_i;
        end
      end
      ST_PROG: begin
        if (tmr_zero_i) begin
          state_d    = ST_HOLD;
          tmr_load_o = 1'b1;
          tmr_val_o  = CW'(ALPHA_LD);
        end
      end
      ST_HOLD: begin
        if (tmr_zero_i) begin
          state_d    = ST_DRAIN;
          tmr_load_o = 1'b1;
          tmr_val_o  = CW'(BETA_LD);
        end
      end
      ST_DRAIN: begin
        if (tmr_zero_i) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    ctl_d = ctl_decode(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cls_q <= 2'b00;
    else if (cls_en) cls_q <= cls_d;
  end

  assign pclass_o = cls_q;
  assign ctl_o    = ctl_q;

endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
  import flash_pulse_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int T_SETUP_US  = 50,
  parameter int T_ALPHA_US  = 5,
  parameter int T_BETA_US   = 5,
  parameter int T_SHORT_US  = 10,
  parameter int T_NORMAL_US = 30,
  parameter int T_LONG_US   = 200,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] pclass_i,
  output logic       wdt_en_o,
  output logic       setup_o,
  output logic       prog_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int SETUP_CYC  = T_SETUP_US  * CLK_MHZ;
  localparam int ALPHA_CYC  = T_ALPHA_US  * CLK_MHZ;
  localparam int BETA_CYC   = T_BETA_US   * CLK_MHZ;
  localparam int SHORT_CYC  = T_SHORT_US  * CLK_MHZ;
  localparam int NORMAL_CYC = T_NORMAL_US * CLK_MHZ;
  localparam int LONG_CYC   = T_LONG_US   * CLK_MHZ;
  localparam int MAX_CYC    = max_of(max_of(max_of(SETUP_CYC, ALPHA_CYC), max_of(BETA_CYC, SHORT_CYC)),
                                     max_of(NORMAL_CYC, LONG_CYC));
  localparam int CW         = $clog2(MAX_CYC + 1);

  logic          rst_sync_n;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] prog_ld;
  logic [1:0]    cls_latched;
  ctl_out_t      ctl;

  rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  prog_width_sel #(
    .CW        (CW),
    .SHORT_LD  (SHORT_CYC - 1),
    .NORMAL_LD (NORMAL_CYC - 1),
    .LONG_LD   (LONG_CYC - 1)
  ) u_wsel (
    .pclass_i   (cls_latched),
    .width_ld_o (prog_ld)
  );

  pulse_timer #(.CW(CW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pulse_seq_fsm #(
    .CW       (CW),
    .SETUP_LD (SETUP_CYC - 1),
    .ALPHA_LD (ALPHA_CYC - 1),
    .BETA_LD  (BETA_CYC - 1)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .pclass_i   (pclass_i),
    .tmr_zero_i (tmr_zero),
    .prog_ld_i  (prog_ld),
    .pclass_o   (cls_latched),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .ctl_o      (ctl)
  );

  assign wdt_en_o = ctl.wdt;
  assign setup_o  = ctl.setup;
  assign prog_o   = ctl.prog;
  assign busy_o   = ctl.busy;
  assign done_o   = ctl.done;

endmodule

// File: rtl/flash_pulse_seq_chk.sv
module flash_pulse_seq_chk (
  input logic clk,
  input logic rst_ok,
  input logic start_i,
  input logic busy,
  input logic wdt,
  input logic setup,
  input logic prog,
  input logic done
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy && start_i) |=> (busy && wdt && !setup));

  p_setup_in_wdt_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    setup |-> wdt);

  p_prog_in_setup_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    prog |-> setup);

  p_setup_after_prog_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(prog) |-> setup);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> (!wdt && !setup && !prog && busy));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy && !done) |=> busy);

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !busy);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !busy |-> (!wdt && !setup && !prog && !done));

endmodule

bind flash_pulse_seq flash_pulse_seq_chk u_chk (
  .clk     (clk),
  .rst_ok  (rst_sync_n),
  .start_i (start_i),
  .busy    (busy_o),
  .wdt     (wdt_en_o),
  .setup   (setup_o),
  .prog    (prog_o),
  .done    (done_o)
);

// File: tb/flash_pulse_seq_test.sv
module flash_pulse_seq_test;

  localparam int SETUP_C  = 5000;
  localparam int ALPHA_C  = 500;
  localparam int BETA_C   = 500;
  localparam int SHORT_C  = 1000;
  localparam int NORMAL_C = 3000;
  localparam int LONG_C   = 20000;
  localparam int WDOG     = 200000;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [1:0] pclass_i;
  logic       wdt_en_o, setup_o, prog_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 0;

  flash_pulse_seq uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .pclass_i (pclass_i),
    .wdt_en_o (wdt_en_o),
    .setup_o  (setup_o),
    .prog_o   (prog_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model: expected {busy,wdt,setup,prog,done} per cycle.
  logic [4:0] exp_q[$];
  logic [4:0] cur = '0;
  int rs = 0;
  int acc_w = 0;

  function automatic int width_of(logic [1:0] c);
    if (c == 2'b00) return SHORT_C;
    if (c == 2'b01) return NORMAL_C;
    return LONG_C;
  endfunction

  task automatic push_seq(int w);
    exp_q.push_back(5'b11000);
    for (int i = 0; i < SETUP_C; i++) exp_q.push_back(5'b11100);
    for (int i = 0; i < w; i++)       exp_q.push_back(5'b11110);
    for (int i = 0; i < ALPHA_C; i++) exp_q.push_back(5'b11100);
    for (int i = 0; i < BETA_C; i++)  exp_q.push_back(5'b11000);
    exp_q.push_back(5'b10001);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      rs  = 0;
      cur = '0;
    end else if (rs < 2) begin
      rs++;
      cur = '0;
    end else begin
      if (!cur[4] && start_i) begin
        acc_w = width_of(pclass_i);
        push_seq(acc_w);
      end
      if (exp_q.size() > 0) cur = exp_q.pop_front();
      else cur = '0;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  int pw = 0;
  bit prog_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == cur[4],   "R8 busy",  busy_o,   cur[4]);
      chk(wdt_en_o == cur[3], "R3 wdt",   wdt_en_o, cur[3]);
      chk(setup_o == cur[2],  "R6 setup", setup_o,  cur[2]);
      chk(prog_o == cur[1],   "R4 prog",  prog_o,   cur[1]);
      chk(done_o == cur[0],   "R7 done",  done_o,   cur[0]);
      if (prog_o) chk(setup_o, "R5 prog without setup", setup_o, 1);
      if (prog_o) pw++;
      if (prog_prev && !prog_o) begin
        chk(pw == acc_w, "R4 measured width", pw, acc_w);
        pw = 0;
      end
      prog_prev = prog_o;
    end else begin
      pw = 0;
      prog_prev = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!done_o) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] c);
    @(negedge clk);
    start_i  = 1'b1;
    pclass_i = c;
    @(negedge clk);
    start_i  = 1'b0;
    // R2: accepted, watchdog up, setup not yet
    chk(busy_o && wdt_en_o && !setup_o, "R2 accept", {busy_o, wdt_en_o, setup_o}, 3'b110);
    @(negedge clk);
    chk(setup_o, "R3 setup one cycle after wdt", setup_o, 1);
  endtask

  initial begin
    rst_n    = 1'b0;
    start_i  = 1'b0;
    pclass_i = 2'b00;
    repeat (3) @(negedge clk);
    chk({wdt_en_o, setup_o, prog_o, busy_o, done_o} == 5'b0, "R1 reset state",
        {wdt_en_o, setup_o, prog_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    // R1: start during synchronizer release is ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(!busy_o, "R1 start during release", busy_o, 0);
    // R10: idle with toggling inputs
    for (int i = 0; i < 4; i++) begin
      pclass_i = 2'(i);
      @(negedge clk);
      chk({wdt_en_o, setup_o, prog_o, busy_o, done_o} == 5'b0, "R10 idle quiet",
          {wdt_en_o, setup_o, prog_o, busy_o, done_o}, 0);
    end

    issue(2'b00); wait_done();
    issue(2'b01); wait_done();

    // R9: start and class change mid-pulse are ignored
    issue(2'b10);
    while (!prog_o) @(negedge clk);
    repeat (10) @(negedge clk);
    start_i  = 1'b1;
    pclass_i = 2'b00;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    chk(prog_o, "R9 pulse kept after mid start", prog_o, 1);
    wait_done();

    // R9: start on the done cycle is ignored
    issue(2'b11);
    wait_done();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o, "R9 start on done ignored", busy_o, 0);
    @(negedge clk);
    chk(!busy_o, "R9 still idle", busy_o, 0);

    // R1: reset during program pulse drops lines at once
    issue(2'b01);
    while (!prog_o) @(negedge clk);
    repeat (5) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk({wdt_en_o, setup_o, prog_o} == 3'b000, "R1 immediate clear",
           {wdt_en_o, setup_o, prog_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(2'b00); wait_done();
    repeat (3) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule